// File: doc/BRIEF.md
# Half-Rate Word Packer

This block accepts one 16-bit word on every rising edge of its input clock and combines each pair of consecutive words into a single 32-bit word. The 32-bit word is presented at half the input rate. The block also exports a half-rate clock for the consumer. That clock comes from a toggle flip-flop inside the block, which is clocked by the input clock.

Each input bit position runs through its own two-stage shift path, so the two most recent words are always on hand. A second register bank captures the finished pair once per output clock period. The output bits therefore change only at the slow rate, and always in step with the exported clock. A flag tells the consumer when the first complete pair has been delivered.

The stream interface has no handshake in either direction, so there is no back-pressure at all. The source must present a new word on every input clock edge. The consumer must take each 32-bit word within the two input cycles it is held. The output word changes on the rising edge of the exported clock, so the consumer samples it on the falling edge.

Top module: `pair_packer`

## Requirements
- R1: `out_clk` inverts on every input clock edge that is not a reset edge, so its period is two input clock periods. It is 0 after reset and 1 after the first edge that follows reset.
- R2: A synchronous active-high `rst` clears `out_clk`, `out_valid` and `out_word` to zero, and it restarts the pairing sequence.
- R3: In each output word, the earlier of the two input words sits in bits [15:0] and the later one sits in bits [31:16].
- R4: `out_word` changes only on input edges where `out_clk` goes from 0 to 1. On every other edge it holds its value.
- R5: `out_valid` is 0 until the first pair is loaded, which happens on the third input edge after reset. From then on it stays 1 until the next reset.
- R6: Counting input edges after reset from 1, the words taken on edges 1 and 2 form the first pair, and each later pair is the next two edges. On edge 2m+1 (m ≥ 1) the output loads the words taken on edges 2m-1 and 2m. No output word ever combines words from two different pairs.
- R7: Words presented while `rst` is high are never included in any output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; one word accepted per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 16 | Input word sampled on every rising edge of `clk` |
| out_clk | output | 1 | Derived clock at half the rate of `clk` |
| out_word | output | 32 | Packed pair: earlier word in the low half, later word in the high half |
| out_valid | output | 1 | High once the first complete pair has been delivered |

## Verification
The assertions assume that `rst` and `in_word` change away from the rising edge of `clk`, and that `rst` is held high from time zero until at least one edge has passed. Under that assumption every register has a defined value before any property is armed. They also assume that a word arrives on every non-reset edge; this is the only traffic the block supports. The stimulus drives both inputs on falling edges and keeps `rst` high for the first two edges. It then drives a new word on every edge. The sequence includes a second reset applied mid-pair, which checks that the phase restarts. The input data keeps changing while `rst` is high.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PP_IN_W = 16;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/pp_toggle_div.sv
module pp_toggle_div
  import pp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase_o
);
  always_ff @(posedge clk) begin
    if (rst) phase_o <= PH_LOW;
    else     phase_o <= (phase_o == PH_LOW) ? PH_HIGH : PH_LOW;
  end

  // R1
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_o != $past(phase_o)));
endmodule

// File: rtl/pp_bit_shift.sv
module pp_bit_shift (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic newer_o,
  output logic older_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      newer_o <= 1'b0;
      older_o <= 1'b0;
    end else begin
      newer_o <= d_i;
      older_o <= newer_o;
    end
  end
endmodule

// File: rtl/pp_pair_shift.sv
module pp_pair_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] newer_o,
  output logic [W-1:0] older_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    pp_bit_shift u_bit (
      .clk     (clk),
      .rst     (rst),
      .d_i     (word_i[b]),
      .newer_o (newer_o[b]),
      .older_o (older_o[b])
    );
  end

  // R6
  stage_advance_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (older_o == $past(newer_o)));
endmodule

// File: rtl/pp_out_reg.sv
module pp_out_reg
  import pp_pkg::*;
#(
  parameter int unsigned W = 16,
  localparam int unsigned OW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        phase_i,
  input  logic [W-1:0]  later_i,
  input  logic [W-1:0]  earlier_i,
  output logic [OW-1:0] word_o,
  output logic          valid_o
);
  logic primed;
  logic load;

  assign load = (phase_i == PH_LOW) && primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (phase_i == PH_HIGH) primed <= 1'b1;
      if (load) begin
        word_o  <= {later_i, earlier_i};
        valid_o <= 1'b1;
      end
    end
  end

  // R4
  hold_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_i == PH_HIGH) |=> $stable(word_o));

  // R5
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  // R5
  quiet_before_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (word_o == '0));
endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import pp_pkg::*;
#(
  parameter int unsigned IN_W = PP_IN_W,
  localparam int unsigned OUT_W = 2 * IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_word,
  output logic             out_clk,
  output logic [OUT_W-1:0] out_word,
  output logic             out_valid
);
  phase_e            phase;
  logic [IN_W-1:0]   newer;
  logic [IN_W-1:0]   older;

  pp_toggle_div u_div (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase)
  );

  pp_pair_shift #(.W(IN_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .word_i  (in_word),
    .newer_o (newer),
    .older_o (older)
  );

  pp_out_reg #(.W(IN_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .phase_i   (phase),
    .later_i   (newer),
    .earlier_i (older),
    .word_o    (out_word),
    .valid_o   (out_valid)
  );

  assign out_clk = (phase == PH_HIGH);

  // R2
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_clk && !out_valid && out_word == '0));

  // R4
  load_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (out_word != $past(out_word)) |-> $rose(out_clk));
endmodule

// File: tb/pair_packer_bench.sv
module pair_packer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_word = '0;
  logic        out_clk;
  logic [31:0] out_word;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;

  int          n = 0;
  logic [15:0] hist[$];
  logic [31:0] exp_word = '0;
  logic        exp_clk = 1'b0;
  logic        exp_vld = 1'b0;
  logic        in_rst = 1'b1;

  always #4 clk = ~clk;

  pair_packer u_pair_packer (
    .clk       (clk),
    .rst       (rst),
    .in_word   (in_word),
    .out_clk   (out_clk),
    .out_word  (out_word),
    .out_valid (out_valid)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic compare();
    string wreq;
    if (in_rst)               wreq = "R2";
    else if (n < 3)           wreq = "R7";
    else if (n % 2 == 1)      wreq = "R3/R6";
    else                      wreq = "R4";
    check(out_clk === exp_clk, in_rst ? "R2" : "R1", {31'b0, out_clk}, {31'b0, exp_clk});
    check(out_valid === exp_vld, in_rst ? "R2" : "R5", {31'b0, out_valid}, {31'b0, exp_vld});
    check(out_word === exp_word, wreq, out_word, exp_word);
  endtask

  task automatic step(input logic r, input logic [15:0] w);
    rst = r;
    in_word = w;
    @(posedge clk);
    in_rst = r;
    if (r) begin
      n = 0;
      hist.delete();
      exp_word = '0;
      exp_vld  = 1'b0;
      exp_clk  = 1'b0;
    end else begin
      n++;
      hist.push_back(w);
      exp_clk = (n % 2 == 1);
      if (n >= 3 && n % 2 == 1) begin
        exp_word = {hist[n-2], hist[n-3]};
        exp_vld  = 1'b1;
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    logic [15:0] lfsr;
    step(1'b1, 16'h1111);
    step(1'b1, 16'h2222);
    // incrementing words, wrapping through 0xFFFF
    for (int i = 0; i < 40; i++) step(1'b0, 16'hFFF0 + 16'(i));
    // alternating all-ones / all-zeros
    for (int i = 0; i < 20; i++) step(1'b0, (i % 2 == 0) ? 16'hFFFF : 16'h0000);
    // walking one
    for (int i = 0; i < 16; i++) step(1'b0, 16'h0001 << i);
    // odd number of words, then reset mid-pair with live data (R7, R2)
    for (int i = 0; i < 5; i++) step(1'b0, 16'hA500 + 16'(i));
    step(1'b1, 16'hDEAD);
    step(1'b1, 16'hBEEF);
    // pseudo-random words after restart (R6)
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      step(1'b0, lfsr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule